// File: doc/BRIEF.md
# SPI Command-Response Slave

This block is an SPI slave that lives entirely in a fast system clock domain. The serial clock, the data-in line and the active-low select are brought in through a short synchronizer chain. Edges of the serial clock are found by comparing successive samples. Two static configuration bits choose the idle level of the serial clock and which of its two edges samples incoming data. Between them they cover all four conventional SPI modes.

Each byte the master shifts in is treated as a command. A command code equal to `CMD_BASE + k` picks read register `k` of a flat register-value input. That register's value is queued as the response, and it is shifted out most significant bit first during the next byte the master clocks. The master may send a filler byte or the next command during that byte. Because of this the reply always trails its command by one byte.

With the streaming option set, the transmit shifter ignores the queued response. It loads the live sample input at the start of every byte, so the master can read a fresh value without sending a command first. Every completed incoming byte is presented on a byte output together with a one-cycle valid strobe.

Top module: `spi_cmd_slave`

## Requirements
- R1: While reset is held and right after it is released, `spi_miso`, `rx_valid_o` and `rx_byte_o` are all zero, and the queued response is 0x00.
- R2: With `cfg_cpol` = 0 the idle serial clock is low, and with 1 it is high. The leading edge is the one leaving the idle level. With `cfg_cpha` = 0, data in is sampled on the leading edge and `spi_miso` changes on the trailing edge. With `cfg_cpha` = 1 the two roles are swapped. All four combinations transfer correctly.
- R3: Each serial clock cycle moves one bit in on `spi_mosi` and one bit out on `spi_miso`, most significant bit first. After every 8th sampled bit, `rx_valid_o` is high for exactly one system cycle and `rx_byte_o` holds the received byte.
- R4: A received byte equal to 0xA0 + k, for k below `NUM_REGS`, selects `reg_file_i[8k+7:8k]`. That value is sent during the next byte, whether that byte falls in the same select frame or in a later one.
- R5: Any other received byte queues 0x00 as the next response.
- R6: With `cfg_stream` = 1, the transmit shifter loads `sample_i` at the start of every byte instead of the queued response.
- R7: With `cfg_cpha` = 0, the first response bit appears on `spi_miso` once select falls, before the first serial clock edge.
- R8: While deselected, `spi_miso` is held at 0 and the bit counter is cleared. A byte cut short by select rising raises no strobe, leaves the queued response unchanged, and does not shift the bit alignment of the next frame.
- R9: Serial clock edges while deselected have no effect: no strobe, `spi_miso` stays 0, and the next frame behaves as if they never occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_stream | input | 1 | 1: load `sample_i` at each byte start |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master, 0 when deselected |
| reg_file_i | input | NUM_REGS*DATA_W | Read register values, register k at bits [8k+7:8k] |
| sample_i | input | DATA_W | Live sample for streaming mode |
| rx_byte_o | output | DATA_W | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe per completed byte |

## Verification
The assertions rely on a few input assumptions. Each serial clock level lasts at least four system cycles, so two sample or shift events never fall in neighbouring cycles. The select line changes only while the serial clock sits at its idle level, and the configuration bits stay static while select is low. The stimulus keeps within these limits. It holds every clock level for eight system cycles and leaves half a serial period between a select edge and the next clock edge. It changes mode, streaming flag and sample value only while select is high.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Events produced by the front end, one system cycle wide each.
  typedef struct packed {
    logic cs_act;   // slave selected (synchronized)
    logic start;    // first cycle of a selected frame
    logic cap;      // sample data-in now
    logic shf;      // advance / reload the transmit shifter now
    logic mosi;     // synchronized data-in bit
  } spi_evt_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_cpol,
  input  logic     cfg_cpha,
  input  logic     spi_sclk,
  input  logic     spi_mosi,
  input  logic     spi_cs_n,
  output logic     rst_n_s,
  output spi_evt_t evt
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic                   rst_meta;
  logic [SYNC_STAGES-1:0] sclk_p, mosi_p, cs_p;
  logic                   sclk_d, cs_d;
  logic                   rise, fall, lead, trail;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sclk_p <= '0;
      mosi_p <= '0;
      cs_p   <= '1;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], spi_sclk};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
      sclk_d <= sclk_p[LAST];
      cs_d   <= cs_p[LAST];
    end
  end

  always_comb begin
    rise       = sclk_p[LAST] & ~sclk_d;
    fall       = ~sclk_p[LAST] & sclk_d;
    lead       = cfg_cpol ? fall : rise;
    trail      = cfg_cpol ? rise : fall;
    evt.cs_act = ~cs_p[LAST];
    evt.start  = ~cs_p[LAST] & cs_d;
    evt.cap    = evt.cs_act & (cfg_cpha ? trail : lead);
    evt.shf    = evt.cs_act & (cfg_cpha ? lead : trail);
    evt.mosi   = mosi_p[LAST];
  end

  // R2: with each clock level lasting several cycles, a sample event is
  // never followed directly by another sample or shift event.
  a_r2_event_spacing: assert property (@(posedge clk) disable iff (!rst_n_s)
    evt.cap |=> !evt.cap && !evt.shf);

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned CMD_BASE = 'hA0
) (
  input  logic [DATA_W-1:0]          cmd_i,
  input  logic [NUM_REGS*DATA_W-1:0] reg_file_i,
  output logic [DATA_W-1:0]          val_o
);

  logic [NUM_REGS-1:0] hit;
  logic [DATA_W-1:0]   masked [NUM_REGS];

  // R4/R5: one comparator per register slot; no match leaves zero.
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    assign hit[k]    = (cmd_i == DATA_W'(CMD_BASE + k));
    assign masked[k] = hit[k] ? reg_file_i[k*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    val_o = '0;
    for (int j = 0; j < NUM_REGS; j++) val_o = val_o | masked[j];
  end

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_REGS    = 4,
  parameter int unsigned CMD_BASE    = 'hA0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_cpol,
  input  logic                       cfg_cpha,
  input  logic                       cfg_stream,
  input  logic                       spi_sclk,
  input  logic                       spi_mosi,
  input  logic                       spi_cs_n,
  output logic                       spi_miso,
  input  logic [NUM_REGS*DATA_W-1:0] reg_file_i,
  input  logic [DATA_W-1:0]          sample_i,
  output logic [DATA_W-1:0]          rx_byte_o,
  output logic                       rx_valid_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic     rst_n_s;
  spi_evt_t evt;

  logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [DATA_W-2:0] rx_sh_q, rx_sh_d;
  logic [DATA_W-1:0] rx_next, dec_val;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] resp_q, resp_d;
  logic [DATA_W-1:0] rx_byte_d;
  logic              rx_valid_d;
  logic              byte_done, load_tx;

  spi_cmd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .cfg_cpha (cfg_cpha),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .rst_n_s  (rst_n_s),
    .evt      (evt)
  );

  assign rx_next = {rx_sh_q, evt.mosi};

  spi_cmd_decode #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .CMD_BASE (CMD_BASE)
  ) u_decode (
    .cmd_i      (rx_next),
    .reg_file_i (reg_file_i),
    .val_o      (dec_val)
  );

  // Next-state logic.
  always_comb begin
    bit_cnt_d  = bit_cnt_q;
    rx_sh_d    = rx_sh_q;
    tx_d       = tx_q;
    resp_d     = resp_q;
    rx_byte_d  = rx_byte_o;
    rx_valid_d = 1'b0;
    byte_done  = evt.cap && (bit_cnt_q == CNT_LAST);
    // Byte start: frame entry, or a shift edge on a byte boundary.
    load_tx    = evt.start || (evt.shf && (bit_cnt_q == '0));

    if (!evt.cs_act) begin
      bit_cnt_d = '0;
    end else begin
      if (evt.cap) begin
        bit_cnt_d = byte_done ? '0 : bit_cnt_q + 1'b1;
        rx_sh_d   = rx_next[DATA_W-2:0];
      end
      if (byte_done) begin
        rx_valid_d = 1'b1;
        rx_byte_d  = rx_next;
        resp_d     = dec_val;
      end
      if (load_tx) begin
        tx_d = cfg_stream ? sample_i : resp_q;
      end else if (evt.shf) begin
        tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      bit_cnt_q  <= '0;
      rx_sh_q    <= '0;
      tx_q       <= '0;
      resp_q     <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      bit_cnt_q  <= bit_cnt_d;
      rx_sh_q    <= rx_sh_d;
      tx_q       <= tx_d;
      resp_q     <= resp_d;
      rx_byte_o  <= rx_byte_d;
      rx_valid_o <= rx_valid_d;
    end
  end

  assign spi_miso = evt.cs_act & tx_q[DATA_W-1];

  // R3: the received-byte strobe is a single cycle.
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_valid_o |=> !rx_valid_o);

  // R4: the queued response only moves when a byte completes.
  a_r4_resp_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rx_valid_o |-> $stable(resp_q));

  // R5: an unmatched command leaves a zero response queued.
  a_r5_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_valid_o && ((int'(rx_byte_o) < int'(CMD_BASE)) ||
                    (int'(rx_byte_o) >= int'(CMD_BASE + NUM_REGS))))
    |-> (resp_q == '0));

  // R8: select held high at the pin keeps the output low.
  a_r8_miso_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);

  // R8: deselection clears the bit counter.
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    !evt.cs_act |=> (bit_cnt_q == '0));

  // R2: within a frame the output moves only after a shift or start event.
  a_r2_miso_steady: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt.cs_act && $past(evt.cs_act) && !$past(evt.shf) && !$past(evt.start))
    |-> $stable(spi_miso));

endmodule

// File: tb/spi_cmd_slave_tb_top.sv
module spi_cmd_slave_tb_top;

  localparam int H = 8;  // system cycles per serial clock level

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_cpol, cfg_cpha, cfg_stream;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso;
  logic [31:0] reg_file;
  logic [7:0]  sample;
  logic [7:0]  rx_byte;
  logic        rx_valid;

  int          n_chk = 0;
  int          n_bad = 0;
  int          vcnt = 0;
  logic [7:0]  last_rx = 8'h00;
  logic [7:0]  exp_resp;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spi_cmd_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_cpol   (cfg_cpol),
    .cfg_cpha   (cfg_cpha),
    .cfg_stream (cfg_stream),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .reg_file_i (reg_file),
    .sample_i   (sample),
    .rx_byte_o  (rx_byte),
    .rx_valid_o (rx_valid)
  );

  // Strobe monitor: counts strobe cycles, keeps the byte seen with each.
  always @(posedge clk) begin
    if (rx_valid) begin
      vcnt    <= vcnt + 1;
      last_rx <= rx_byte;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] cmd);
    if (cmd >= 8'hA0 && cmd <= 8'hA3) return reg_file[(cmd - 8'hA0)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic m);
    if (!cfg_cpha) begin
      spi_mosi = b;
      wait_n(H);
      spi_sclk = ~cfg_cpol;
      m = spi_miso;
      wait_n(H);
      spi_sclk = cfg_cpol;
    end else begin
      spi_sclk = ~cfg_cpol;
      spi_mosi = b;
      wait_n(H);
      spi_sclk = cfg_cpol;
      m = spi_miso;
      wait_n(H);
    end
  endtask

  // One byte: checks response, strobe count and received byte (R3).
  task automatic xfer(input logic [7:0] cmd, input string req);
    int         v0 = vcnt;
    logic [7:0] got;
    logic [7:0] expv;
    logic       m;
    expv = cfg_stream ? sample : exp_resp;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(cmd[i], m);
      got[i] = m;
    end
    wait_n(2);
    chk(req, got, expv);
    chk("R3 strobe count", 8'(vcnt - v0), 8'd1);
    chk("R3 rx byte", last_rx, cmd);
    exp_resp = model(cmd);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic strm);
    cfg_cpol   = pol;
    cfg_cpha   = pha;
    cfg_stream = strm;
    spi_sclk   = pol;
    wait_n(H);
  endtask

  task automatic frame3(input logic [7:0] c0, c1, c2, input string req);
    spi_cs_n = 1'b0;
    wait_n(H);
    xfer(c0, req);
    xfer(c1, req);
    xfer(c2, req);
    wait_n(H);
    spi_cs_n = 1'b1;
    wait_n(2*H);
  endtask

  task automatic t_reset();
    chk("R1 miso", {7'd0, spi_miso}, 8'h00);
    chk("R1 valid", {7'd0, rx_valid}, 8'h00);
    chk("R1 rx byte", rx_byte, 8'h00);
  endtask

  // R2/R4/R5 in every mode; R4 also carries the response across frames.
  task automatic t_modes();
    for (int md = 0; md < 4; md++) begin
      set_mode(md[1], md[0], 1'b0);
      frame3(8'hA0, 8'hA1, 8'hA2, "R2 R4 mode response");
      frame3(8'hA3, 8'h55, 8'hA1, "R4 R5 mode response");
    end
  endtask

  task automatic t_unknown();
    set_mode(1'b0, 1'b0, 1'b0);
    frame3(8'hFF, 8'hA2, 8'h00, "R5 unknown code");
    frame3(8'h9F, 8'hA4, 8'hA3, "R5 edge codes");
  endtask

  // R7: first bit visible before any clock edge in both CPHA=0 modes.
  task automatic t_first_bit();
    for (int p = 0; p < 2; p++) begin
      set_mode(p[0], 1'b0, 1'b0);
      frame3(8'hA1, 8'hA0, 8'hA0, "R7 setup");
      spi_cs_n = 1'b0;
      wait_n(H - 2);
      chk("R7 first bit", {7'd0, spi_miso}, {7'd0, exp_resp[7]});
      wait_n(2);
      xfer(8'hA1, "R7 first byte");
      wait_n(H);
      spi_cs_n = 1'b1;
      wait_n(H - 2);
      spi_cs_n = 1'b0;
      wait_n(H - 2);
      chk("R7 first bit", {7'd0, spi_miso}, {7'd0, exp_resp[7]});
      wait_n(2);
      xfer(8'h00, "R7 second frame");
      wait_n(H);
      spi_cs_n = 1'b1;
      wait_n(2*H);
    end
  endtask

  task automatic t_stream();
    set_mode(1'b0, 1'b1, 1'b1);
    sample = 8'h96;
    wait_n(2);
    frame3(8'hA0, 8'h11, 8'hA2, "R6 stream");
    set_mode(1'b1, 1'b1, 1'b1);
    sample = 8'h27;
    wait_n(2);
    frame3(8'h00, 8'hA3, 8'hA1, "R6 stream");
    set_mode(1'b0, 1'b0, 1'b1);
    sample = 8'hE1;
    wait_n(2);
    frame3(8'hA2, 8'hA2, 8'h7E, "R6 stream");
    set_mode(1'b0, 1'b0, 1'b0);
    frame3(8'hA0, 8'hA3, 8'hA2, "R6 back to command");
  endtask

  // R8: cut a byte short, then check idle output, strobe and alignment.
  task automatic t_abort();
    int   v0;
    logic m;
    for (int p = 0; p < 2; p++) begin
      set_mode(1'b0, p[0], 1'b0);
      frame3(8'hA2, 8'hA1, 8'hA3, "R8 setup");
      v0 = vcnt;
      spi_cs_n = 1'b0;
      wait_n(H);
      for (int i = 0; i < 3; i++) bit_cycle(1'b1, m);
      wait_n(H);
      spi_cs_n = 1'b1;
      wait_n(4);
      chk("R8 miso low", {7'd0, spi_miso}, 8'h00);
      chk("R8 no strobe", 8'(vcnt - v0), 8'd0);
      frame3(8'hA0, 8'h5C, 8'hA1, "R8 after abort");
    end
  endtask

  // R9: clock activity while deselected.
  task automatic t_idle_clock();
    int v0;
    set_mode(1'b1, 1'b0, 1'b0);
    frame3(8'hA3, 8'hA0, 8'hA2, "R9 setup");
    v0 = vcnt;
    for (int i = 0; i < 11; i++) begin
      spi_mosi = i[0];
      spi_sclk = ~spi_sclk;
      wait_n(H);
    end
    spi_sclk = cfg_cpol;
    wait_n(H);
    chk("R9 no strobe", 8'(vcnt - v0), 8'd0);
    chk("R9 miso low", {7'd0, spi_miso}, 8'h00);
    frame3(8'hA1, 8'hA3, 8'h42, "R9 after idle clock");
  endtask

  initial begin
    rst_n      = 1'b0;
    cfg_cpol   = 1'b0;
    cfg_cpha   = 1'b0;
    cfg_stream = 1'b0;
    spi_sclk   = 1'b0;
    spi_mosi   = 1'b0;
    spi_cs_n   = 1'b1;
    reg_file   = {8'h3C, 8'hC3, 8'h5A, 8'h81};
    sample     = 8'h00;
    exp_resp   = 8'h00;
    wait_n(5);
    t_reset();
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_modes();
    t_unknown();
    t_first_bit();
    t_stream();
    t_abort();
    t_idle_clock();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule